// File: doc/BRIEF.md
# Camera Sensor Register Loader over a Two-Wire Control Bus

This block brings up an image sensor by writing a fixed list of register/value pairs to it over a simplified two-wire serial control bus. It is the only master on the bus and needs no external sequencing. When `cfg_enable` is seen high, the block works through the list in order. Each pair goes out as one single-byte write. At the end of the list it can optionally perform one single-byte read, for example of an identification register. The byte read back is shown on `id_byte`. `cfg_done` is then raised and stays high until reset.

The bus clock is made by dividing the system clock. Each bit slot lasts four quarter periods of `QTR` system cycles, so a 25 MHz clock with `QTR = 62` gives about 100 kHz. The data line is open-drain. The block only ever pulls it low through `sda_pull_low` and reads the resolved level on `sda_i`; a pull-up outside the block supplies the high level. The ninth bit of every 9-bit unit is treated as a don't-care slot. A read never uses a repeated start: the register address is sent in a write that ends in a stop, and the byte is then fetched in a new transaction. No data stream enters or leaves the block. The read-back result is a held status word with a level qualifier, so there is no back-pressure to manage.

The register list is computed inside the block and has `NUM_PAIRS` entries. A full sensor set-up uses around 160 or more pairs.

Top module: `cam_cfg_top`

## Requirements
- R1: After reset `scl_o` is 1, `sda_pull_low` is 0, and `cfg_done` and `id_valid` are 0. The bus stays idle (both lines high) until `cfg_enable` is sampled high.
- R2: Within a 9-bit unit, consecutive rising edges of `scl_o` are exactly 4*`QTR` system cycles apart.
- R3: The data line changes only while `scl_o` is low, with two exceptions. It may fall while `scl_o` is high to form a start, and it may rise while `scl_o` is high to form a stop. Starts and stops happen only on unit boundaries.
- R4: A register write is one transaction of three units, each sent MSB first: the device write address `{DEV_ADDR,1'b0}`, then the register address, then the value. In each unit the master releases the line for the ninth bit.
- R5: Whatever level the slave puts on a ninth bit that the slave owns (low or high), the block carries on with the next unit or transaction unchanged.
- R6: Pair k, for k = 0 to `NUM_PAIRS`-1, has register address (8'h10 + 3k) mod 256 and value ((37k) mod 256) XOR 8'h5A. The pairs are sent in increasing k.
- R7: From a stop to the next start, at least 4*`QTR` cycles pass with both lines high.
- R8: With `RD_EN` set, the read happens after the last pair and has two parts. First a write transaction of `{DEV_ADDR,0}` and `RD_REG`, closed by a stop. Then a new transaction (never a repeated start) of `{DEV_ADDR,1}`, followed by 8 bits driven by the slave. In that data unit the master keeps the line released, which gives a high NA in the ninth bit. A stop follows.
- R9: The byte read in R8, MSB first, appears on `id_byte`, and `id_valid` goes high and is held until reset.
- R10: `cfg_done` goes high only after the stop (and gap) of the final transaction. It then stays high with the bus idle until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Starts the load sequence when sampled high |
| scl_o | output | 1 | Bus clock |
| sda_pull_low | output | 1 | 1 pulls the data line low; 0 releases it |
| sda_i | input | 1 | Resolved data-line level |
| cfg_done | output | 1 | High once all transactions have finished |
| id_valid | output | 1 | High once the read-back byte has been captured |
| id_byte | output | 8 | Read-back register value |

## Verification
The bus outputs are registered from the bit engine's state, so every level change lags the quarter-phase state by one cycle. The spacing of events does not depend on this lag. Within a unit, successive clock rises are therefore exactly 4*`QTR` cycles apart. Between units one extra issue cycle is allowed, and stop-to-start gaps must be at least 4*`QTR` cycles. The monitor samples the bus on the falling system-clock edge and decodes starts, stops and bits from the levels it sees. Each stop is matched against the scoreboard entry that the driver task queued, and the done flag, the ID byte and the sticky behaviour are checked once the final stop has been seen.

// File: rtl/cam_cfg_pkg.sv
package cam_cfg_pkg;

  typedef enum logic [1:0] {
    SYM_GAP   = 2'd0,
    SYM_START = 2'd1,
    SYM_STOP  = 2'd2,
    SYM_UNIT  = 2'd3
  } sym_e;

  // Register/value pair k of the load list: {reg, value}
  function automatic logic [15:0] cfg_pair(input int unsigned k);
    logic [7:0] ra;
    logic [7:0] va;
    ra = 8'(32'h10 + 3 * k);
    va = 8'(37 * k) ^ 8'h5A;
    return {ra, va};
  endfunction

endpackage

// File: rtl/cam_cfg_bitgen.sv
module cam_cfg_bitgen
  import cam_cfg_pkg::*;
#(
  parameter int QTR = 62
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  sym_e       kind,
  input  logic [7:0] tx_byte,
  input  logic       rx_mode,
  input  logic       sda_i,
  output logic       busy,
  output logic       slot_end,
  output logic [7:0] rx_byte,
  output logic       scl_o,
  output logic       sda_low_o
);
  localparam int TW = (QTR > 1) ? $clog2(QTR) : 1;

  logic          busy_q;
  sym_e          kind_q;
  logic [8:0]    sh_q;
  logic          rxm_q;
  logic [3:0]    bit_q;
  logic [1:0]    qtr_q;
  logic [TW-1:0] tick_q;
  logic [7:0]    rx_q;
  logic          scl_q, sdl_q;
  logic          lvl_scl, lvl_sda;

  wire tick_end = (tick_q == TW'(QTR - 1));
  wire sym_last = (kind_q != SYM_UNIT) || (bit_q == 4'd8);

  // Line levels per quarter of the current bit slot
  always_comb begin
    lvl_scl = 1'b1;
    lvl_sda = 1'b1;
    unique case (kind_q)
      SYM_START: begin
        lvl_scl = (qtr_q != 2'd3);
        lvl_sda = (qtr_q == 2'd0);
      end
      SYM_STOP: begin
        lvl_scl = (qtr_q != 2'd0);
        lvl_sda = (qtr_q >= 2'd2);
      end
      SYM_UNIT: begin
        lvl_scl = (qtr_q == 2'd1) || (qtr_q == 2'd2);
        lvl_sda = rxm_q ? 1'b1 : sh_q[8];
      end
      default: begin
        lvl_scl = 1'b1;
        lvl_sda = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      kind_q <= SYM_GAP;
      sh_q   <= '1;
      rxm_q  <= 1'b0;
      bit_q  <= '0;
      qtr_q  <= '0;
      tick_q <= '0;
      rx_q   <= '0;
      scl_q  <= 1'b1;
      sdl_q  <= 1'b0;
    end else if (!busy_q) begin
      if (go) begin
        busy_q <= 1'b1;
        kind_q <= kind;
        sh_q   <= {tx_byte, 1'b1};
        rxm_q  <= rx_mode;
        bit_q  <= '0;
        qtr_q  <= '0;
        tick_q <= '0;
      end
    end else begin
      scl_q <= lvl_scl;
      sdl_q <= !lvl_sda;
      if (kind_q == SYM_UNIT && qtr_q == 2'd2 && tick_q == '0 && bit_q < 4'd8)
        rx_q <= {rx_q[6:0], sda_i};
      if (tick_end) begin
        tick_q <= '0;
        qtr_q  <= qtr_q + 2'd1;
        if (qtr_q == 2'd3) begin
          if (sym_last) begin
            busy_q <= 1'b0;
          end else begin
            bit_q <= bit_q + 4'd1;
            sh_q  <= {sh_q[7:0], 1'b1};
          end
        end
      end else begin
        tick_q <= tick_q + TW'(1);
      end
    end
  end

  assign busy      = busy_q;
  assign slot_end  = busy_q && tick_end && (qtr_q == 2'd3) && sym_last;
  assign rx_byte   = rx_q;
  assign scl_o     = scl_q;
  assign sda_low_o = sdl_q;

endmodule

// File: rtl/cam_cfg_seq.sv
module cam_cfg_seq
  import cam_cfg_pkg::*;
#(
  parameter int       NUM_PAIRS = 8,
  parameter bit       RD_EN     = 1'b1,
  parameter bit [6:0] DEV_ADDR  = 7'h21,
  parameter bit [7:0] RD_REG    = 8'h0A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       slot_end,
  output logic       go,
  output sym_e       kind,
  output logic [7:0] tx_byte,
  output logic       rx_mode,
  output logic       done,
  output logic       id_load
);
  localparam int ITEMS = NUM_PAIRS + (RD_EN ? 1 : 0);
  localparam int IW    = $clog2(ITEMS + 1);
  localparam logic [7:0] DEV_W = {DEV_ADDR, 1'b0};
  localparam logic [7:0] DEV_R = {DEV_ADDR, 1'b1};

  typedef enum logic [1:0] {SQ_WAIT, SQ_ISSUE, SQ_BUSY, SQ_DONE} sq_e;

  sq_e         st_q;
  logic [IW-1:0] item_q;
  logic [3:0]  step_q;
  logic [3:0]  last_step;
  logic        rd_item;
  logic [15:0] pair;

  assign rd_item = RD_EN && (item_q == IW'(NUM_PAIRS));
  assign pair    = cfg_pair(32'(item_q));

  always_comb begin
    kind      = SYM_GAP;
    tx_byte   = 8'hFF;
    rx_mode   = 1'b0;
    last_step = rd_item ? 4'd9 : 4'd5;
    if (!rd_item) begin
      unique case (step_q)
        4'd0: kind = SYM_START;
        4'd1: begin kind = SYM_UNIT; tx_byte = DEV_W;      end
        4'd2: begin kind = SYM_UNIT; tx_byte = pair[15:8]; end
        4'd3: begin kind = SYM_UNIT; tx_byte = pair[7:0];  end
        4'd4: kind = SYM_STOP;
        default: kind = SYM_GAP;
      endcase
    end else begin
      unique case (step_q)
        4'd0, 4'd5: kind = SYM_START;
        4'd1: begin kind = SYM_UNIT; tx_byte = DEV_W;  end
        4'd2: begin kind = SYM_UNIT; tx_byte = RD_REG; end
        4'd6: begin kind = SYM_UNIT; tx_byte = DEV_R;  end
        4'd7: begin kind = SYM_UNIT; rx_mode = 1'b1;   end
        4'd3, 4'd8: kind = SYM_STOP;
        default: kind = SYM_GAP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SQ_WAIT;
      item_q <= '0;
      step_q <= '0;
    end else begin
      unique case (st_q)
        SQ_WAIT:  if (enable) st_q <= SQ_ISSUE;
        SQ_ISSUE: st_q <= SQ_BUSY;
        SQ_BUSY: if (slot_end) begin
          if (step_q == last_step) begin
            step_q <= '0;
            if (item_q == IW'(ITEMS - 1)) begin
              st_q <= SQ_DONE;
            end else begin
              item_q <= item_q + IW'(1);
              st_q   <= SQ_ISSUE;
            end
          end else begin
            step_q <= step_q + 4'd1;
            st_q   <= SQ_ISSUE;
          end
        end
        default: st_q <= SQ_DONE;
      endcase
    end
  end

  assign go      = (st_q == SQ_ISSUE);
  assign done    = (st_q == SQ_DONE);
  assign id_load = (st_q == SQ_BUSY) && slot_end && rd_item && (step_q == 4'd7);

endmodule

// File: rtl/cam_cfg_top.sv
module cam_cfg_top
  import cam_cfg_pkg::*;
#(
  parameter int       QTR       = 62,
  parameter int       NUM_PAIRS = 8,
  parameter bit       RD_EN     = 1'b1,
  parameter bit [6:0] DEV_ADDR  = 7'h21,
  parameter bit [7:0] RD_REG    = 8'h0A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_enable,
  output logic       scl_o,
  output logic       sda_pull_low,
  input  logic       sda_i,
  output logic       cfg_done,
  output logic       id_valid,
  output logic [7:0] id_byte
);
  logic       eng_go, eng_busy, eng_end, seq_rxm, id_load;
  sym_e       seq_kind;
  logic [7:0] seq_tx, eng_rx;

  cam_cfg_seq #(
    .NUM_PAIRS(NUM_PAIRS), .RD_EN(RD_EN), .DEV_ADDR(DEV_ADDR), .RD_REG(RD_REG)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .slot_end(eng_end),
    .go(eng_go), .kind(seq_kind), .tx_byte(seq_tx), .rx_mode(seq_rxm),
    .done(cfg_done), .id_load(id_load)
  );

  cam_cfg_bitgen #(.QTR(QTR)) u_bit (
    .clk(clk), .rst_n(rst_n), .go(eng_go), .kind(seq_kind), .tx_byte(seq_tx),
    .rx_mode(seq_rxm), .sda_i(sda_i), .busy(eng_busy), .slot_end(eng_end),
    .rx_byte(eng_rx), .scl_o(scl_o), .sda_low_o(sda_pull_low)
  );

  generate
    if (RD_EN) begin : g_id
      logic [7:0] id_q;
      logic       idv_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          id_q  <= '0;
          idv_q <= 1'b0;
        end else if (id_load) begin
          id_q  <= eng_rx;
          idv_q <= 1'b1;
        end
      end
      assign id_byte  = id_q;
      assign id_valid = idv_q;
    end else begin : g_no_id
      assign id_byte  = 8'h00;
      assign id_valid = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/cam_cfg_chk.sv
module cam_cfg_chk #(
  parameter bit RD_EN = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_enable,
  input logic scl_o,
  input logic sda_pull_low,
  input logic cfg_done,
  input logic id_valid,
  input logic eng_busy,
  input logic seq_rxm
);
  logic seen_en;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_en <= 1'b0;
    else if (cfg_enable) seen_en <= 1'b1;
  end

  p_idle_until_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_en |-> (scl_o && !sda_pull_low));

  p_scl_high_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_o) |=> scl_o);

  p_scl_low_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_o) |=> !scl_o);

  p_read_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && seq_rxm) |-> !sda_pull_low);

  p_id_before_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> (id_valid || !RD_EN));

  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> cfg_done);

  p_done_bus_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> (scl_o && !sda_pull_low));

endmodule

bind cam_cfg_top cam_cfg_chk #(.RD_EN(RD_EN)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .scl_o(scl_o),
  .sda_pull_low(sda_pull_low), .cfg_done(cfg_done), .id_valid(id_valid),
  .eng_busy(eng_busy), .seq_rxm(seq_rxm)
);

// File: tb/cam_cfg_top_tb_top.sv
module cam_cfg_top_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int         Q    = 4;
  localparam int         NP   = 8;
  localparam logic [6:0] DEV  = 7'h21;
  localparam logic [7:0] RREG = 8'h0A;
  localparam logic [7:0] IDV  = 8'hB6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic slave_low = 1'b0;
  wire  scl, sdl, done, idv;
  wire [7:0] idb;
  wire  sda = !(sdl | slave_low);

  always #2.5 clk = ~clk;

  cam_cfg_top #(.QTR(Q), .NUM_PAIRS(NP), .RD_EN(1'b1), .DEV_ADDR(DEV), .RD_REG(RREG)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(en), .scl_o(scl), .sda_pull_low(sdl),
    .sda_i(sda), .cfg_done(done), .id_valid(idv), .id_byte(idb)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Scoreboard: {len[2:0], b0, b1, b2}
  logic [26:0] exp_q[$];

  task automatic push_exp(input int len, input logic [7:0] b0, input logic [7:0] b1,
                          input logic [7:0] b2);
    exp_q.push_back({3'(len), b0, b1, b2});
  endtask

  // Bus monitor and slave model
  bit         p_scl = 1'b1, p_sda = 1'b1, in_frame = 1'b0, had_stop = 1'b0, en_seen = 1'b0;
  int         cyc = 0, last_rise = 0, last_stop = 0, bitcnt = 0, nb = 0, trcount = 0;
  int         quiet_bad = 0;
  logic [7:0] sh = '0;
  logic [7:0] bs[3];

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      p_scl = 1'b1; p_sda = 1'b1; in_frame = 1'b0; bitcnt = 0; nb = 0;
      slave_low = 1'b0;
    end else begin
      if (en) en_seen = 1'b1;
      if (!en_seen && (!scl || !sda)) quiet_bad++;
      if (scl && p_scl && sda != p_sda) begin
        if (!sda) begin
          // start
          check(!in_frame, "R8", "start inside a transaction", 1, 0);
          if (had_stop)
            check(cyc - last_stop >= 4 * Q, "R7", "stop-to-start gap", cyc - last_stop, 4 * Q);
          in_frame = 1'b1; bitcnt = 0; nb = 0; bs[0] = '0; bs[1] = '0; bs[2] = '0;
        end else begin
          // stop: its own clock rise was counted as a partial bit
          check(in_frame && bitcnt == 1, "R3", "stop off unit boundary", bitcnt, 1);
          in_frame = 1'b0; had_stop = 1'b1; last_stop = cyc; trcount++; bitcnt = 0;
          if (exp_q.size() == 0) begin
            check(1'b0, "R6", "unexpected transaction", nb, 0);
          end else begin
            logic [26:0] e;
            e = exp_q.pop_front();
            check({3'(nb), bs[0], bs[1], bs[2]} == e, "R4 R5 R6 R8", "transaction",
                  int'({3'(nb), bs[0], bs[1], bs[2]}), int'(e));
          end
        end
      end
      if (scl && !p_scl) begin
        if (!in_frame) check(1'b0, "R3", "clock pulse outside a transaction", 0, 1);
        if (bitcnt < 8) begin
          if (bitcnt > 0)
            check(cyc - last_rise == 4 * Q, "R2", "bit period", cyc - last_rise, 4 * Q);
          sh = {sh[6:0], sda};
          bitcnt++;
        end else begin
          if (nb == 1 && bs[0][0])
            check(sda == 1'b1, "R8", "NA bit on read data", int'(sda), 1);
          if (nb < 3) bs[nb] = sh;
          nb++;
          bitcnt = 0;
        end
        last_rise = cyc;
      end
      if (!scl && p_scl) begin
        if (nb == 1 && bs[0][0] && bitcnt < 8)
          slave_low = !IDV[7 - bitcnt];
        else if (bitcnt == 8 && !(nb == 1 && bs[0][0]))
          slave_low = trcount[0];  // R5: alternate low and high in slave-owned ninth bits
        else
          slave_low = 1'b0;
      end
      p_scl = scl; p_sda = sda;
    end
  end

  initial begin
    for (int k = 0; k < NP; k++)
      push_exp(3, {DEV, 1'b0}, 8'(8'h10 + 3 * k), 8'(37 * k) ^ 8'h5A);
    push_exp(2, {DEV, 1'b0}, RREG, 8'h00);
    push_exp(2, {DEV, 1'b1}, IDV, 8'h00);

    repeat (10) @(negedge clk);
    check(scl == 1'b1, "R1", "scl in reset", int'(scl), 1);
    check(sdl == 1'b0, "R1", "sda pull in reset", int'(sdl), 0);
    check(done == 1'b0, "R1", "done in reset", int'(done), 0);
    check(idv == 1'b0, "R1", "id_valid in reset", int'(idv), 0);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    check(quiet_bad == 0, "R1", "bus activity before enable", quiet_bad, 0);
    check(done == 1'b0, "R10", "done before enable", int'(done), 0);
    en = 1'b1;
    @(negedge clk);
    en = 1'b0;

    begin
      int n;
      n = 0;
      while (!done && n < 100000) begin
        @(negedge clk);
        n++;
        if (!done && trcount == NP + 2 && exp_q.size() != 0)
          check(1'b0, "R10", "queue mismatch", exp_q.size(), 0);
      end
      check(done == 1'b1, "R10", "watchdog: done never rose", int'(done), 1);
    end

    check(trcount == NP + 2, "R10", "transactions before done", trcount, NP + 2);
    check(exp_q.size() == 0, "R6", "expected items left", exp_q.size(), 0);
    check(!in_frame, "R10", "bus open at done", int'(in_frame), 0);
    check(idv == 1'b1, "R9", "id_valid at done", int'(idv), 1);
    check(idb == IDV, "R9", "id_byte", int'(idb), int'(IDV));
    en = 1'b1;
    repeat (200) @(negedge clk);
    en = 1'b0;
    check(done == 1'b1, "R10", "done sticky", int'(done), 1);
    check(trcount == NP + 2, "R10", "no traffic after done", trcount, NP + 2);
    check(scl && sda, "R10", "bus idle after done", int'({scl, sda}), 3);
    check(idb == IDV && idv, "R9", "id held", int'(idb), int'(IDV));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R10", "done cleared by reset", int'(done), 0);
    check(idv == 1'b0, "R1", "id_valid cleared by reset", int'(idv), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule